// File: doc/BRIEF.md
# Fractional-Baud UART Transceiver

A full-duplex asynchronous serial transceiver for the mark/space NRZ line format. The idle line sits high, a frame opens with one low start bit, carries its data bits least significant first and closes with one or two high stop bits. A single fractional baud generator gives an oversampling tick to both directions, so transmit and receive always run at the same rate. The receiver checks each bit with a three-sample majority vote near the bit centre.

The parallel side has two valid/ready channels, one for words to send and one for received words. Static configuration inputs set the divisor (12-bit integer part, 4-bit fraction), the oversampling factor (16 or 8), the word length (8 or 9 bits) and the number of transmitted stop bits. The factor of 8 doubles the top rate to one bit per eight clocks. The factor of 16 places the samples more finely and so tolerates more clock deviation. Each received word carries noise and framing flags, and a sticky overrun flag reports a word that was lost.

Top module: `uart_frac_core`

## Requirements
- R1: After reset, tx_o is 1, tx_ready_o is 1, and rx_valid_o, rx_frame_err_o, rx_noise_o and rx_overrun_o are 0.
- R2: The oversampling tick period, in sixteenths of a clock, is D = mant*16 + frac with the factor 16, and D = mant*16 + 2*frac[2:0] with the factor 8, where frac[3] is ignored. Ticks come from an accumulator that adds 16 per clock and fires (subtracting D) whenever the sum reaches D, starting from 0 at reset. Any D below 16 acts as 16.
- R3: When tx_valid_i and tx_ready_o are both high at an edge, tx_o goes low at that edge. The start bit lasts until the OS-th tick after acceptance (OS = 16 or 8). Every later bit lasts exactly OS ticks. Data bits go out LSB first, and stop bits are high.
- R4: With word9_i=1 a frame carries 9 data bits. With word9_i=0 it carries 8, and tx_data_i[8] has no effect on tx_o.
- R5: With stop2_i=1 a frame has two stop bits, and with stop2_i=0 it has one. tx_ready_o rises at the edge that ends the last stop bit.
- R6: tx_ready_o is low while a frame is in flight. tx_valid_i asserted during that time is ignored and does not change tx_o.
- R7: A received word is presented on rx_data_o with rx_valid_o and held stable until an edge where rx_ready_i is high. In 8-bit mode rx_data_o[8] is 0.
- R8: A falling edge starts a frame only if the line is still low at sample position OS/2. A shorter low pulse produces no word.
- R9: Each bit is decided by majority over the samples at positions OS/2-1, OS/2 and OS/2+1. Any disagreement within a frame sets rx_noise_o with that word.
- R10: A low majority on the stop bit sets rx_frame_err_o with that word, and the data is still delivered.
- R11: If a word completes while the previous word is still unread, the new word is discarded and rx_overrun_o is set. rx_overrun_o clears when the held word is read.
- R12: With the factor 8 and D = 16, each bit lasts 8 clocks on transmit, and receive decodes words at that rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_mant_i | input | 12 | Divisor integer part |
| div_frac_i | input | 4 | Divisor fraction in sixteenths |
| os8_i | input | 1 | 1: oversample by 8, 0: by 16 |
| word9_i | input | 1 | 1: 9-bit words, 0: 8-bit |
| stop2_i | input | 1 | 1: two transmit stop bits |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Transmitter can accept a word |
| tx_data_i | input | 9 | Transmit word |
| tx_o | output | 1 | Serial output |
| rx_i | input | 1 | Serial input |
| rx_valid_o | output | 1 | Received word valid |
| rx_ready_i | input | 1 | Received word consumed |
| rx_data_o | output | 9 | Received word |
| rx_frame_err_o | output | 1 | Stop bit sampled low for this word |
| rx_noise_o | output | 1 | Sample disagreement in this frame |
| rx_overrun_o | output | 1 | A word was lost while this one was held |

## Verification
The transmit side is exact to the cycle. tx_o goes low at the accepting edge, and every bit boundary falls on a tick that the bench predicts from the divisor arithmetic alone, so tx_o and tx_ready_o are compared after every edge. On the receive side the bench changes rx_i only just after a predicted tick. Because the synchronizer adds a fixed delay, each slot the bench drives maps onto one receiver sample position, and a single slot can be aimed at the centre sample to inject noise. A received word is due at the tick of the stop bit's last centre sample. The bench reads the receive outputs only once the stop bit and a margin of idle slots have gone by, and it checks the absence of a word after a false start only after a long idle window.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int MANT_W = 12;
  localparam int FRAC_W = 4;
  localparam int DATA_W = 9;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              os8_i,
  output logic              tick_o
);
  localparam int DIV_W = MANT_W + FRAC_W;
  localparam int UNIT  = 1 << FRAC_W;

  logic [DIV_W-1:0] div_raw, div_eff;
  logic [DIV_W:0]   acc, sum;

  // by-8 mode drops the fraction MSB and doubles the rest
  always_comb begin
    div_raw = os8_i ? {mant_i, frac_i[FRAC_W-2:0], 1'b0} : {mant_i, frac_i};
    div_eff = (div_raw < DIV_W'(UNIT)) ? DIV_W'(UNIT) : div_raw;
    sum     = acc + (DIV_W+1)'(UNIT);
    tick_o  = sum >= {1'b0, div_eff};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc <= '0;
    else         acc <= tick_o ? sum - {1'b0, div_eff} : sum;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              os8_i,
  input  logic              word9_i,
  input  logic              stop2_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o
);
  localparam int SH_W = DATA_W + 2;
  localparam int BW   = $clog2(DATA_W + 3);

  logic            busy;
  logic [3:0]      cnt, last;
  logic [BW-1:0]   left, n_load;
  logic [SH_W-1:0] sh, sh_load;

  always_comb begin
    last    = os8_i ? 4'd7 : 4'd15;
    sh_load = word9_i ? {2'b11, data_i} : {3'b111, data_i[DATA_W-2:0]};
    n_load  = (word9_i ? BW'(DATA_W) : BW'(DATA_W-1)) + (stop2_i ? BW'(2) : BW'(1));
    ready_o = !busy;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      tx_o <= 1'b1;
      cnt  <= '0;
      left <= '0;
      sh   <= '1;
    end else if (!busy) begin
      if (valid_i) begin
        busy <= 1'b1;
        tx_o <= 1'b0;
        cnt  <= '0;
        sh   <= sh_load;
        left <= n_load;
      end
    end else if (tick_i) begin
      if (cnt == last) begin
        cnt <= '0;
        if (left == '0) begin
          busy <= 1'b0;
          tx_o <= 1'b1;
        end else begin
          tx_o <= sh[0];
          sh   <= {1'b1, sh[SH_W-1:1]};
          left <= left - BW'(1);
        end
      end else begin
        cnt <= cnt + 4'd1;
      end
    end
  end

  // R1
  tx_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> tx_o);
  // R3
  tx_start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !tx_o);
  // R3
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !tick_i) |=> $stable(tx_o));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              os8_i,
  input  logic              word9_i,
  input  logic              rx_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              noise_o,
  output logic              overrun_o
);
  localparam int IW = $clog2(DATA_W + 3);

  logic              r1, r2, busy, s0, s1, nacc;
  logic [3:0]        cnt, nxt, last, mid;
  logic [IW-1:0]     idx, nbits;
  logic [DATA_W-1:0] sh, word;
  logic              vote, dis, done, take;

  always_comb begin
    mid   = os8_i ? 4'd4 : 4'd8;
    last  = os8_i ? 4'd7 : 4'd15;
    nbits = word9_i ? IW'(DATA_W) : IW'(DATA_W-1);
    nxt   = (cnt == last) ? 4'd0 : cnt + 4'd1;
    vote  = maj3(s0, s1, r2);
    dis   = (s0 != s1) || (s1 != r2);
    done  = tick_i && busy && (nxt == mid + 4'd1) && (idx == nbits + IW'(1));
    take  = valid_o && ready_i;
    word  = word9_i ? sh : {1'b0, sh[DATA_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1 <= 1'b1;
      r2 <= 1'b1;
    end else begin
      r1 <= rx_i;
      r2 <= r1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      s0   <= 1'b1;
      s1   <= 1'b1;
      nacc <= 1'b0;
      sh   <= '0;
    end else if (tick_i) begin
      if (!busy) begin
        if (!r2) begin
          busy <= 1'b1;
          cnt  <= '0;
          idx  <= '0;
        end
      end else begin
        cnt <= nxt;
        if (cnt == last) idx <= idx + IW'(1);
        if (nxt == mid - 4'd1) s0 <= r2;
        if (nxt == mid) begin
          s1 <= r2;
          if (idx == '0 && r2) busy <= 1'b0;  // false start
        end
        if (nxt == mid + 4'd1) begin
          if (idx == '0) nacc <= dis;
          else if (idx <= nbits) begin
            sh   <= {vote, sh[DATA_W-1:1]};
            nacc <= nacc | dis;
          end else busy <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      data_o      <= '0;
      frame_err_o <= 1'b0;
      noise_o     <= 1'b0;
      overrun_o   <= 1'b0;
    end else if (done && !(valid_o && !take)) begin
      valid_o     <= 1'b1;
      data_o      <= word;
      frame_err_o <= !vote;
      noise_o     <= nacc | dis;
      overrun_o   <= 1'b0;
    end else if (done) begin
      overrun_o <= 1'b1;
    end else if (take) begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      noise_o     <= 1'b0;
      overrun_o   <= 1'b0;
    end
  end

  // R7
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
  // R11
  rx_ovr_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> valid_o);
  // R9 R10
  rx_flag_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o || noise_o) |-> valid_o);
endmodule

// File: rtl/uart_frac_core.sv
module uart_frac_core
  import uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MANT_W-1:0] div_mant_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic              os8_i,
  input  logic              word9_i,
  input  logic              stop2_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_frame_err_o,
  output logic              rx_noise_o,
  output logic              rx_overrun_o
);
  logic tick;

  uart_baud_gen #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_baud (
    .clk_i, .rst_ni, .mant_i(div_mant_i), .frac_i(div_frac_i), .os8_i, .tick_o(tick)
  );

  uart_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .os8_i, .word9_i, .stop2_i,
    .valid_i(tx_valid_i), .ready_o(tx_ready_o), .data_i(tx_data_i), .tx_o
  );

  uart_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .os8_i, .word9_i, .rx_i,
    .valid_o(rx_valid_o), .ready_i(rx_ready_i), .data_o(rx_data_o),
    .frame_err_o(rx_frame_err_o), .noise_o(rx_noise_o), .overrun_o(rx_overrun_o)
  );
endmodule

// File: tb/uart_frac_core_test.sv
module uart_frac_core_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [11:0] mant = 12'd4;
  logic [3:0]  frac = 4'd0;
  logic os8 = 1'b0, w9 = 1'b0, s2 = 1'b0;
  logic tx_valid = 1'b0, rx_line = 1'b1, rx_ready = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_ready, tx_line, rx_valid, ferr, noise, ovr;
  logic [8:0] rx_data;

  always #5 clk = ~clk;

  uart_frac_core uut (
    .clk_i(clk), .rst_ni, .div_mant_i(mant), .div_frac_i(frac), .os8_i(os8),
    .word9_i(w9), .stop2_i(s2), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_data_i(tx_data), .tx_o(tx_line), .rx_i(rx_line), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .rx_data_o(rx_data), .rx_frame_err_o(ferr),
    .rx_noise_o(noise), .rx_overrun_o(ovr)
  );

  int vectors = 0, miscompares = 0, ncyc = 0;
  int macc, mdiv, mos, mrem;
  bit m_ready, last_tick;
  bit q[$];
  string tx_req = "R3";

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // one clock: advance reference model, then compare transmit side
  task automatic cyc();
    bit mt;
    int nb;
    mt = (macc + 16 >= mdiv);
    macc = mt ? macc + 16 - mdiv : macc + 16;
    if (m_ready && tx_valid) begin
      nb = w9 ? 9 : 8;
      q = {};
      q.push_back(1'b0);
      for (int i = 0; i < nb; i++) q.push_back(tx_data[i]);
      q.push_back(1'b1);
      if (s2) q.push_back(1'b1);
      mrem = mos;
      m_ready = 0;
    end else if (!m_ready && mt) begin
      mrem--;
      if (mrem == 0) begin
        void'(q.pop_front());
        mrem = mos;
        if (q.size() == 0) m_ready = 1;
      end
    end
    last_tick = mt;
    @(posedge clk);
    @(negedge clk);
    ncyc++;
    chk(tx_line === ((q.size() != 0) ? q[0] : 1'b1), tx_req, tx_line, (q.size() != 0) ? q[0] : 1);
    chk(tx_ready === m_ready, "R6", tx_ready, m_ready);
    if (ncyc > 150000) begin
      chk(0, "watchdog", ncyc, 0);
      finish_run();
    end
  endtask

  task automatic apply_cfg(int mt, int fr, bit o8, bit nine, bit two);
    int raw;
    rst_ni = 0; tx_valid = 0; rx_line = 1; rx_ready = 0;
    mant = 12'(mt); frac = 4'(fr); os8 = o8; w9 = nine; s2 = two;
    raw = o8 ? mt * 16 + (fr % 8) * 2 : mt * 16 + fr;
    mdiv = (raw < 16) ? 16 : raw;
    mos = o8 ? 8 : 16;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    macc = 0; q = {}; m_ready = 1; mrem = 0;
    chk(tx_line === 1'b1 && tx_ready === 1'b1, "R1", {tx_line, tx_ready}, 3);
    chk(!rx_valid && !ferr && !noise && !ovr, "R1", {rx_valid, ferr, noise, ovr}, 0);
  endtask

  task automatic send_tx(int d);
    while (!m_ready) cyc();
    tx_data = 9'(d);
    tx_valid = 1;
    cyc();
    tx_valid = 0;
    while (!m_ready) cyc();
    repeat (3) cyc();
  endtask

  task automatic wait_tick();
    do cyc(); while (!last_tick);
  endtask

  // drive one frame slot per tick; glitch inverts one slot
  task automatic send_rx(int d, int nb, int glitch, bit stop_val);
    int slots;
    bit b;
    slots = (nb + 2) * mos;
    wait_tick();
    for (int t = 0; t < slots; t++) begin
      if (t < mos) b = 0;
      else if (t < (nb + 1) * mos) b = d[t / mos - 1];
      else b = stop_val;
      rx_line = b ^ (t == glitch);
      wait_tick();
    end
    rx_line = 1;
    repeat (4) wait_tick();
  endtask

  task automatic rx_take();
    rx_ready = 1;
    cyc();
    rx_ready = 0;
    chk(rx_valid === 1'b0, "R7", rx_valid, 0);
  endtask

  initial begin
    #1_900_000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // integer divisor, by 16, 8N1
    apply_cfg(4, 0, 0, 0, 0);
    tx_req = "R3"; send_tx(9'h0A5);
    tx_req = "R4"; send_tx(9'h13C);  // bit 8 ignored in 8-bit mode
    send_rx(8'h5A, 8, -1, 1);
    chk(rx_valid && rx_data == 9'h05A, "R7", rx_data, 9'h05A);
    chk(!noise && !ferr, "R7", {noise, ferr}, 0);
    repeat (20) cyc();
    chk(rx_valid && rx_data == 9'h05A, "R7", rx_data, 9'h05A);
    rx_take();
    // R8: short low pulse
    wait_tick();
    rx_line = 0;
    repeat (3) wait_tick();
    rx_line = 1;
    repeat (40) wait_tick();
    chk(rx_valid === 1'b0, "R8", rx_valid, 0);
    send_rx(8'hC3, 8, -1, 1);
    chk(rx_valid && rx_data == 9'h0C3, "R8", rx_data, 9'h0C3);
    rx_take();
    // R9: centre sample of data bit 3 inverted
    send_rx(8'h96, 8, 4 * 16 + 8, 1);
    chk(rx_valid && rx_data == 9'h096, "R9", rx_data, 9'h096);
    chk(noise === 1'b1, "R9", noise, 1);
    rx_take();
    // R10: low stop bit
    send_rx(8'h3C, 8, -1, 0);
    chk(rx_valid && rx_data == 9'h03C, "R10", rx_data, 9'h03C);
    chk(ferr === 1'b1, "R10", ferr, 1);
    rx_take();
    repeat (20) wait_tick();
    chk(rx_valid === 1'b0, "R10", rx_valid, 0);
    // R11: second word arrives unread
    send_rx(8'h11, 8, -1, 1);
    send_rx(8'h22, 8, -1, 1);
    chk(rx_valid && rx_data == 9'h011, "R11", rx_data, 9'h011);
    chk(ovr === 1'b1, "R11", ovr, 1);
    rx_take();
    chk(ovr === 1'b0, "R11", ovr, 0);

    // fractional 1.5, 9 data bits, two stop bits
    apply_cfg(1, 8, 0, 1, 1);
    tx_req = "R5"; send_tx(9'h1A5);
    send_tx(9'h0F0);
    // R6: valid raised mid-frame is ignored
    tx_data = 9'h155; tx_valid = 1; cyc(); tx_valid = 0;
    repeat (40) cyc();
    tx_data = 9'h0AA; tx_valid = 1;
    repeat (20) cyc();
    tx_valid = 0;
    while (!m_ready) cyc();
    repeat (3) cyc();
    send_rx(9'h1C6, 9, -1, 1);
    chk(rx_valid && rx_data == 9'h1C6, "R4", rx_data, 9'h1C6);
    rx_take();

    // by 8, frac[3] ignored: 1 + 3/8
    apply_cfg(1, 11, 1, 0, 1);
    tx_req = "R2"; send_tx(9'h06E);
    send_rx(8'hB7, 8, -1, 1);
    chk(rx_valid && rx_data == 9'h0B7 && !noise, "R2", rx_data, 9'h0B7);
    rx_take();

    // by 8 at full rate
    apply_cfg(1, 0, 1, 0, 0);
    tx_req = "R12"; send_tx(9'h081);
    send_rx(8'h4D, 8, 3 * 8 + 4, 1);
    chk(rx_valid && rx_data == 9'h04D, "R12", rx_data, 9'h04D);
    chk(noise === 1'b1, "R12", noise, 1);
    rx_take();

    // divisor below one clock clamps
    apply_cfg(0, 5, 0, 0, 0);
    tx_req = "R2"; send_tx(9'h042);

    finish_run();
  end
endmodule